// File: doc/BRIEF.md
# Two-Port Shared-Channel Switchover Controller

This block decodes commands from two host ports, A and B, that share one peripheral channel, and it decides which port owns that channel. Each port presents an 8-bit command code with a 16-bit data word. The data word carries one odd-parity bit per byte. Every command gets a registered response one cycle later. The response holds a 3-bit completion code and, for read commands, a 16-bit result. The controller keeps, for each port, the flags that make up that port's status word: reserve, posted time-out, incurred time-out and alerts. It also drives the console acknowledge lamps.

Ownership changes in two ways. In manual mode the operator's select input picks the owner directly. In automatic mode ownership moves only through a guarded takeover, and that takeover is accepted only after the other port has suffered a watchdog time-out. The watchdog timer and the interrupt delivery logic are separate blocks. The controller signals them with one-cycle strobes, such as start, restart, attention, exception and clear. It reads back from them the running state, the expired state, the expiry event and the per-port interrupt-pending flags.

When several refusal reasons apply at once, the lowest-numbered completion code wins. Busy therefore outranks every error.

Top module: `swx_ctrl`

## Requirements
- R1: Each data byte needs odd parity, meaning the byte and its parity bit together hold an odd number of ones; `cmd_par_i[p][1]` covers bits 15:8 and `[0]` covers bits 7:0. A parity failure returns code 5 and suppresses the command, unless the command returns 1, 3 or 4 first or is one that always returns 7.
- R2: Code 0x20 returns the word 0x0030 with code 7. Code 0x60 (interrupt setup) returns code 7 and pulses `prep_wr_o[p]` with the data word on `prep_data_o[p]`. Both return only code 5 or code 7.
- R3: Code 0x23 returns the reader's status word with code 7. The layout is: bit0 reader owns the channel, bit1 manual mode, bit2 other port timed out, bit3 reserved by the other port, bit4 timer running, bit5 reader incurred a time-out, bits 7:6 zero, bit8 select alert, bit9 mode alert, bit10 load blocked, bit11 reader is port A, bits 13:12 initial period, bits 15:14 warning period. The read clears the reader's bits 9:8.
- R4: Code 0x63 (takeover) returns 1 when busy. It returns 3 in manual mode, when the issuer already owns the channel, or when the issuer has no posted time-out. Otherwise it returns 7, pulses `chan_rst_o` in the response cycle, and moves `owner_o` to the issuer one cycle later.
- R5: Code 0x53 (reserve) returns 3 in manual mode or when the issuer owns the channel. It returns 4 when the timer has expired. On code 7 it sets the other port's status bit3 and pulses that port's `attn_rsv_o` bit.
- R6: Code 0x66 (start monitor) returns 3 in manual mode or when the issuer does not own the channel. It returns 4 when the timer has expired. On code 7 it pulses `mon_start_o`, with `mon_test_o` equal to data bit 0.
- R7: Codes 0x50, 0x53, 0x63 and 0x66 return 1 (busy) without acting in three cases: the issuer's interrupt is pending, a handover is in progress, or the command arrives on port B in the same cycle as a port A command.
- R8: Code 0x6F (device reset) always returns 7. It pulses `clr_irq_o[p]` and clears the issuer's lamp, the issuer's alerts and the other port's reserve bit. Code 0x6C (restart) always returns 7. Both pulse `mon_restart_o` when the issuer owns the channel.
- R9: Code 0x50 lights the issuer's `ack_o` lamp. The lamp is cleared by the issuer's device reset and by any operator change of select or mode.
- R10: In automatic mode a `tmo_evt_i` pulse sets the owner's incurred bit5 and the other port's bit2. In the same registered cycle it pulses `exc_o` for the owner and `attn_go_o` for the other port.
- R11: In manual mode `owner_o` follows `select_i` (0 = A) with one cycle of delay, and posted time-outs are cleared. A change of `select_i` or `manual_i` sets the select alert or the mode alert for both ports.
- R12: Any other command code returns 3 and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 2 | Command strobe per port (bit0 = A) |
| cmd_code_i | input | 2x8 | Command code per port |
| cmd_data_i | input | 2x16 | Data word per port |
| cmd_par_i | input | 2x2 | Odd parity per byte per port |
| manual_i | input | 1 | Operator manual mode |
| select_i | input | 1 | Operator port select (0 = A) |
| ipl_block_i | input | 1 | Load-blocked flag for status bit10 |
| init_sel_i | input | 2 | Initial period setting |
| warn_sel_i | input | 2 | Warning period setting |
| irq_pend_i | input | 2 | Interrupt pending per port |
| tmr_run_i | input | 1 | Timer running |
| tmr_expired_i | input | 1 | Timer has expired |
| tmo_evt_i | input | 1 | Timer expiry event pulse |
| rsp_valid_o | output | 2 | Response strobe per port |
| rsp_cc_o | output | 2x3 | Completion code per port |
| rsp_data_o | output | 2x16 | Read result per port |
| owner_o | output | 1 | Channel owner (0 = A) |
| chan_rst_o | output | 1 | Shared-channel reset pulse |
| mon_start_o | output | 1 | Timer start strobe |
| mon_test_o | output | 1 | Timer test mode with start |
| mon_restart_o | output | 1 | Timer restart strobe |
| prep_wr_o | output | 2 | Interrupt setup write per port |
| prep_data_o | output | 2x16 | Interrupt setup word per port |
| clr_irq_o | output | 2 | Clear pending interrupts per port |
| attn_rsv_o | output | 2 | Reserve attention per port |
| attn_go_o | output | 2 | Takeover go-ahead attention per port |
| exc_o | output | 2 | Time-out exception per port |
| ack_o | output | 2 | Acknowledge lamp per port |

## Verification
The command decoder is tried in three kinds of situation. Each has every gating input clear except one, namely ownership, manual mode, timer expiry, pending interrupt or a bad parity byte, so each refusal code can be traced to one cause. Cases where two causes overlap, such as a pending interrupt with a bad parity byte, or a port B command colliding with port A, show that the lower code wins. The takeover path runs in order: rejected before any time-out, then the expiry event, then accepted. This shows that the interlock opens only on a posted time-out, and that the channel reset comes one cycle before the change of owner. Status reads before and after each event separate the per-port flags from one another.

// File: rtl/swx_pkg.sv
package swx_pkg;
  localparam int NP     = 2;
  localparam int CODE_W = 8;
  localparam int DATA_W = 16;
  localparam int PAR_W  = DATA_W / 8;
  localparam int CC_W   = 3;

  typedef enum logic [CC_W-1:0] {
    CC_NONE = 3'd0, CC_BUSY = 3'd1, CC_REJECT = 3'd3,
    CC_INTERV = 3'd4, CC_PARITY = 3'd5, CC_OK = 3'd7
  } cc_e;

  localparam logic [CODE_W-1:0] OP_RD_ID   = 8'h20;
  localparam logic [CODE_W-1:0] OP_RD_ST   = 8'h23;
  localparam logic [CODE_W-1:0] OP_ACK     = 8'h50;
  localparam logic [CODE_W-1:0] OP_RSV     = 8'h53;
  localparam logic [CODE_W-1:0] OP_PREP    = 8'h60;
  localparam logic [CODE_W-1:0] OP_CONN    = 8'h63;
  localparam logic [CODE_W-1:0] OP_START   = 8'h66;
  localparam logic [CODE_W-1:0] OP_RESTART = 8'h6C;
  localparam logic [CODE_W-1:0] OP_DRESET  = 8'h6F;

  typedef struct packed {
    logic rd_id, rd_st, ack, rsv, prep, conn, start, restart, dreset;
  } act_t;

  function automatic logic [DATA_W-1:0] build_status(
      logic own, logic man, logic tmo_oth, logic rsv, logic run, logic inc,
      logic sel_al, logic mode_al, logic ipl, logic is_a,
      logic [1:0] init_p, logic [1:0] warn_p);
    return {warn_p, init_p, is_a, ipl, mode_al, sel_al, 2'b00,
            inc, run, rsv, tmo_oth, man, own};
  endfunction
endpackage

// File: rtl/swx_parity.sv
module swx_parity #(
  parameter int DW = 16,
  localparam int PW = DW / 8
) (
  input  logic [DW-1:0] data_i,
  input  logic [PW-1:0] par_i,
  output logic          ok_o
);
  logic [PW-1:0] byte_ok;
  for (genvar b = 0; b < PW; b++) begin : g_byte
    assign byte_ok[b] = ^{data_i[8*b +: 8], par_i[b]};
  end
  assign ok_o = &byte_ok;
endmodule

// File: rtl/swx_port_dec.sv
module swx_port_dec
  import swx_pkg::*;
(
  input  logic              valid_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [PAR_W-1:0]  par_i,
  input  logic              busy_i,
  input  logic              manual_i,
  input  logic              owns_i,
  input  logic              tmo_posted_i,
  input  logic              tmr_exp_i,
  output cc_e               cc_o,
  output act_t              act_o
);
  logic par_ok;
  swx_parity #(.DW(DATA_W)) u_par (.data_i(data_i), .par_i(par_i), .ok_o(par_ok));

  cc_e pcc;
  assign pcc = par_ok ? CC_OK : CC_PARITY;

  always_comb begin
    act_o = '0;
    unique case (code_i)
      OP_RD_ID, OP_RD_ST, OP_PREP: cc_o = pcc;
      OP_RESTART, OP_DRESET:       cc_o = CC_OK;
      OP_ACK:   cc_o = busy_i ? CC_BUSY : pcc;
      OP_RSV:   cc_o = busy_i ? CC_BUSY : (manual_i || owns_i) ? CC_REJECT :
                       tmr_exp_i ? CC_INTERV : pcc;
      OP_START: cc_o = busy_i ? CC_BUSY : (manual_i || !owns_i) ? CC_REJECT :
                       tmr_exp_i ? CC_INTERV : pcc;
      OP_CONN:  cc_o = busy_i ? CC_BUSY :
                       (manual_i || owns_i || !tmo_posted_i) ? CC_REJECT : pcc;
      default:  cc_o = CC_REJECT;
    endcase
    if (valid_i && cc_o == CC_OK) begin
      act_o.rd_id   = (code_i == OP_RD_ID);
      act_o.rd_st   = (code_i == OP_RD_ST);
      act_o.ack     = (code_i == OP_ACK);
      act_o.rsv     = (code_i == OP_RSV);
      act_o.prep    = (code_i == OP_PREP);
      act_o.conn    = (code_i == OP_CONN);
      act_o.start   = (code_i == OP_START);
      act_o.restart = (code_i == OP_RESTART);
      act_o.dreset  = (code_i == OP_DRESET);
    end
  end
endmodule

// File: rtl/swx_ctrl.sv
module swx_ctrl
  import swx_pkg::*;
#(
  parameter logic [DATA_W-1:0] ID_WORD = 16'h0030
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NP-1:0]                cmd_valid_i,
  input  logic [NP-1:0][CODE_W-1:0]    cmd_code_i,
  input  logic [NP-1:0][DATA_W-1:0]    cmd_data_i,
  input  logic [NP-1:0][PAR_W-1:0]     cmd_par_i,
  input  logic                         manual_i,
  input  logic                         select_i,
  input  logic                         ipl_block_i,
  input  logic [1:0]                   init_sel_i,
  input  logic [1:0]                   warn_sel_i,
  input  logic [NP-1:0]                irq_pend_i,
  input  logic                         tmr_run_i,
  input  logic                         tmr_expired_i,
  input  logic                         tmo_evt_i,
  output logic [NP-1:0]                rsp_valid_o,
  output logic [NP-1:0][CC_W-1:0]      rsp_cc_o,
  output logic [NP-1:0][DATA_W-1:0]    rsp_data_o,
  output logic                         owner_o,
  output logic                         chan_rst_o,
  output logic                         mon_start_o,
  output logic                         mon_test_o,
  output logic                         mon_restart_o,
  output logic [NP-1:0]                prep_wr_o,
  output logic [NP-1:0][DATA_W-1:0]    prep_data_o,
  output logic [NP-1:0]                clr_irq_o,
  output logic [NP-1:0]                attn_rsv_o,
  output logic [NP-1:0]                attn_go_o,
  output logic [NP-1:0]                exc_o,
  output logic [NP-1:0]                ack_o
);
  logic          owner_q, hand_q, hand_port_q, sel_q, man_q;
  logic [NP-1:0] rsv_q, tmo_oth_q, tmo_inc_q, sel_al_q, mode_al_q, ack_q;
  logic [NP-1:0] busy, owns;
  cc_e           cc  [NP];
  act_t          act [NP];

  for (genvar p = 0; p < NP; p++) begin : g_port
    // port B loses a same-cycle collision against port A
    if (p == 0) begin : g_a
      assign busy[p] = irq_pend_i[p] | hand_q;
    end else begin : g_b
      assign busy[p] = irq_pend_i[p] | hand_q | cmd_valid_i[0];
    end
    assign owns[p] = (owner_q == 1'(p));
    swx_port_dec u_dec (
      .valid_i(cmd_valid_i[p]), .code_i(cmd_code_i[p]), .data_i(cmd_data_i[p]),
      .par_i(cmd_par_i[p]), .busy_i(busy[p]), .manual_i(manual_i),
      .owns_i(owns[p]), .tmo_posted_i(tmo_oth_q[p]), .tmr_exp_i(tmr_expired_i),
      .cc_o(cc[p]), .act_o(act[p]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owner_q <= 1'b0; hand_q <= 1'b0; hand_port_q <= 1'b0;
      sel_q <= 1'b0; man_q <= 1'b0;
      rsv_q <= '0; tmo_oth_q <= '0; tmo_inc_q <= '0;
      sel_al_q <= '0; mode_al_q <= '0; ack_q <= '0;
      rsp_valid_o <= '0; rsp_cc_o <= '0; rsp_data_o <= '0;
      chan_rst_o <= 1'b0; mon_start_o <= 1'b0; mon_test_o <= 1'b0;
      mon_restart_o <= 1'b0; prep_wr_o <= '0; prep_data_o <= '0;
      clr_irq_o <= '0; attn_rsv_o <= '0; attn_go_o <= '0; exc_o <= '0;
    end else begin
      chan_rst_o <= 1'b0; mon_start_o <= 1'b0; mon_restart_o <= 1'b0;
      prep_wr_o <= '0; clr_irq_o <= '0; attn_rsv_o <= '0;
      attn_go_o <= '0; exc_o <= '0;
      sel_q <= select_i; man_q <= manual_i;

      if (hand_q) begin
        owner_q <= hand_port_q;
        hand_q  <= 1'b0;
      end

      for (int p = 0; p < NP; p++) begin
        rsp_valid_o[p] <= cmd_valid_i[p];
        rsp_cc_o[p]    <= cmd_valid_i[p] ? cc[p] : CC_NONE;
        rsp_data_o[p]  <= act[p].rd_id ? ID_WORD :
                          act[p].rd_st ? build_status(owns[p], manual_i, tmo_oth_q[p],
                              rsv_q[p], tmr_run_i, tmo_inc_q[p], sel_al_q[p],
                              mode_al_q[p], ipl_block_i, (p == 0), init_sel_i,
                              warn_sel_i) : '0;
        if (act[p].rd_st) begin
          sel_al_q[p] <= 1'b0; mode_al_q[p] <= 1'b0;
        end
        if (act[p].ack) ack_q[p] <= 1'b1;
        if (act[p].rsv) begin
          rsv_q[1-p] <= 1'b1; attn_rsv_o[1-p] <= 1'b1;
        end
        if (act[p].prep) begin
          prep_wr_o[p] <= 1'b1; prep_data_o[p] <= cmd_data_i[p];
        end
        if (act[p].start) begin
          mon_start_o <= 1'b1; mon_test_o <= cmd_data_i[p][0];
        end
        if ((act[p].restart || act[p].dreset) && owns[p]) mon_restart_o <= 1'b1;
        if (act[p].dreset) begin
          clr_irq_o[p] <= 1'b1; ack_q[p] <= 1'b0; rsv_q[1-p] <= 1'b0;
          sel_al_q[p] <= 1'b0; mode_al_q[p] <= 1'b0;
        end
        if (act[p].conn) begin
          chan_rst_o <= 1'b1; hand_q <= 1'b1; hand_port_q <= 1'(p);
        end
      end

      if (tmo_evt_i && !manual_i) begin
        tmo_inc_q[owner_q]  <= 1'b1; exc_o[owner_q]      <= 1'b1;
        tmo_oth_q[!owner_q] <= 1'b1; attn_go_o[!owner_q] <= 1'b1;
      end
      // operator actions override command effects in the same cycle
      if (select_i != sel_q) begin
        sel_al_q <= '1; ack_q <= '0;
      end
      if (manual_i != man_q) begin
        mode_al_q <= '1; ack_q <= '0;
      end
      if (manual_i) begin
        owner_q <= select_i; tmo_oth_q <= '0;
      end
    end
  end

  assign owner_o = owner_q;
  assign ack_o   = ack_q;
endmodule

// File: rtl/swx_ctrl_chk.sv
module swx_ctrl_chk
  import swx_pkg::*;
(
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [NP-1:0]             cmd_valid_i,
  input logic [NP-1:0][CODE_W-1:0] cmd_code_i,
  input logic                      manual_i,
  input logic                      select_i,
  input logic [NP-1:0]             irq_pend_i,
  input logic [NP-1:0]             rsp_valid_o,
  input logic [NP-1:0][CC_W-1:0]   rsp_cc_o,
  input logic                      owner_o,
  input logic                      chan_rst_o,
  input logic                      mon_start_o
);
  assert_cc_legal_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o[0] |-> (rsp_cc_o[0] inside {3'd1, 3'd3, 3'd4, 3'd5, 3'd7}));

  assert_dreset_ok_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i[1] && cmd_code_i[1] == 8'h6F) |=> (rsp_valid_o[1] && rsp_cc_o[1] == 3'd7));

  assert_busy_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i[0] && irq_pend_i[0] && cmd_code_i[0] == 8'h50) |=> (rsp_cc_o[0] == 3'd1));

  assert_collide_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i == 2'b11 && cmd_code_i[1] == 8'h53) |=> (rsp_cc_o[1] == 3'd1));

  assert_chan_rst_cmd_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_rst_o |-> ($past(cmd_valid_i) != 2'b00 && !$past(manual_i)));

  assert_start_auto_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mon_start_o |-> !$past(manual_i));

  assert_manual_owner_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    manual_i |=> (owner_o == $past(select_i)));
endmodule

bind swx_ctrl swx_ctrl_chk chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_code_i(cmd_code_i),
  .manual_i(manual_i), .select_i(select_i), .irq_pend_i(irq_pend_i),
  .rsp_valid_o(rsp_valid_o), .rsp_cc_o(rsp_cc_o), .owner_o(owner_o),
  .chan_rst_o(chan_rst_o), .mon_start_o(mon_start_o));

// File: tb/swx_ctrl_tb_top.sv
module swx_ctrl_tb_top;
  import swx_pkg::*;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [1:0] cmd_valid = '0;
  logic [1:0][7:0] cmd_code = '0;
  logic [1:0][15:0] cmd_data = '0;
  logic [1:0][1:0] cmd_par = '0;
  logic manual = 1'b0, sel = 1'b0, ipl_blk = 1'b0, tmr_run = 1'b0;
  logic tmr_exp = 1'b0, tmo_evt = 1'b0;
  logic [1:0] init_sel = 2'b01, warn_sel = 2'b10, irq_pend = '0;
  logic [1:0] rsp_valid, prep_wr, clr_irq, attn_rsv, attn_go, exc, ack;
  logic [1:0][2:0] rsp_cc;
  logic [1:0][15:0] rsp_data, prep_data;
  logic owner, chan_rst, mon_start, mon_test, mon_restart;

  swx_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_code_i(cmd_code),
    .cmd_data_i(cmd_data), .cmd_par_i(cmd_par), .manual_i(manual), .select_i(sel),
    .ipl_block_i(ipl_blk), .init_sel_i(init_sel), .warn_sel_i(warn_sel),
    .irq_pend_i(irq_pend), .tmr_run_i(tmr_run), .tmr_expired_i(tmr_exp),
    .tmo_evt_i(tmo_evt), .rsp_valid_o(rsp_valid), .rsp_cc_o(rsp_cc),
    .rsp_data_o(rsp_data), .owner_o(owner), .chan_rst_o(chan_rst),
    .mon_start_o(mon_start), .mon_test_o(mon_test), .mon_restart_o(mon_restart),
    .prep_wr_o(prep_wr), .prep_data_o(prep_data), .clr_irq_o(clr_irq),
    .attn_rsv_o(attn_rsv), .attn_go_o(attn_go), .exc_o(exc), .ack_o(ack));

  int n_chk = 0, n_bad = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] good_par(input logic [15:0] d);
    return {~^d[15:8], ~^d[7:0]};
  endfunction

  task automatic load(input int p, input logic [7:0] code, input logic [15:0] data,
                      input bit bad);
    cmd_valid[p] = 1'b1; cmd_code[p] = code; cmd_data[p] = data;
    cmd_par[p] = good_par(data) ^ {1'b0, bad};
  endtask

  // drive at a falling edge, response sampled at the next falling edge
  task automatic cmd(input int p, input logic [7:0] code, input logic [15:0] data,
                     input bit bad);
    @(negedge clk); load(p, code, data, bad);
    @(negedge clk); cmd_valid = '0;
  endtask

  task automatic t_reset;
    check("R1 reset rsp_valid", 32'(rsp_valid), 0);
    check("R11 reset owner", 32'(owner), 0);
    check("R9 reset ack", 32'(ack), 0);
  endtask

  task automatic t_read_id;
    cmd(0, 8'h20, 16'h0, 0);
    check("R2 id cc", 32'(rsp_cc[0]), 7);
    check("R2 id word", 32'(rsp_data[0]), 32'h0030);
    cmd(1, 8'h20, 16'h0, 1);
    check("R1 id bad parity cc", 32'(rsp_cc[1]), 5);
    check("R1 id bad parity data", 32'(rsp_data[1]), 0);
    cmd(1, 8'h60, 16'h0013, 0);
    check("R2 prep cc", 32'(rsp_cc[1]), 7);
    check("R2 prep strobe", 32'(prep_wr), 32'b10);
    check("R2 prep word", 32'(prep_data[1]), 32'h0013);
  endtask

  task automatic t_status;
    cmd(0, 8'h23, 16'h0, 0);
    check("R3 status A", 32'(rsp_data[0]), 32'h9801);
    cmd(1, 8'h23, 16'h0, 0);
    check("R3 status B", 32'(rsp_data[1]), 32'h9000);
  endtask

  task automatic t_ack;
    cmd(0, 8'h50, 16'h0, 0);
    check("R9 ack cc", 32'(rsp_cc[0]), 7);
    check("R9 ack lamp", 32'(ack), 32'b01);
    irq_pend = 2'b10;
    cmd(1, 8'h50, 16'h0, 1);
    check("R7 ack busy beats parity", 32'(rsp_cc[1]), 1);
    check("R9 ack busy no lamp", 32'(ack), 32'b01);
    irq_pend = 2'b00;
  endtask

  task automatic t_reserve;
    cmd(0, 8'h53, 16'h0, 0);
    check("R5 reserve by owner", 32'(rsp_cc[0]), 3);
    cmd(1, 8'h53, 16'h0, 0);
    check("R5 reserve cc", 32'(rsp_cc[1]), 7);
    check("R5 reserve attention", 32'(attn_rsv), 32'b01);
    cmd(0, 8'h23, 16'h0, 0);
    check("R5 reserve bit A", 32'(rsp_data[0][3]), 1);
    tmr_exp = 1'b1;
    cmd(1, 8'h53, 16'h0, 0);
    check("R5 reserve expired", 32'(rsp_cc[1]), 4);
    tmr_exp = 1'b0;
  endtask

  task automatic t_start;
    cmd(1, 8'h66, 16'h1, 0);
    check("R6 start non-owner", 32'(rsp_cc[1]), 3);
    tmr_exp = 1'b1;
    cmd(0, 8'h66, 16'h1, 0);
    check("R6 start expired", 32'(rsp_cc[0]), 4);
    check("R6 start expired no strobe", 32'(mon_start), 0);
    tmr_exp = 1'b0;
    cmd(0, 8'h66, 16'h1, 1);
    check("R1 start parity cc", 32'(rsp_cc[0]), 5);
    check("R1 start parity suppressed", 32'(mon_start), 0);
    cmd(0, 8'h66, 16'h1, 0);
    check("R6 start cc", 32'(rsp_cc[0]), 7);
    check("R6 start strobe", 32'({mon_start, mon_test}), 32'b11);
  endtask

  task automatic t_restart;
    cmd(0, 8'h6C, 16'h0, 0);
    check("R8 restart cc", 32'(rsp_cc[0]), 7);
    check("R8 restart strobe", 32'(mon_restart), 1);
    cmd(1, 8'h6C, 16'h0, 1);
    check("R8 restart non-owner cc", 32'(rsp_cc[1]), 7);
    check("R8 restart non-owner strobe", 32'(mon_restart), 0);
  endtask

  task automatic t_takeover;
    cmd(1, 8'h63, 16'h0, 0);
    check("R4 takeover no time-out", 32'(rsp_cc[1]), 3);
    @(negedge clk); tmo_evt = 1'b1;
    @(negedge clk); tmo_evt = 1'b0;
    check("R10 exception to A", 32'(exc), 32'b01);
    check("R10 go-ahead to B", 32'(attn_go), 32'b10);
    cmd(1, 8'h23, 16'h0, 0);
    check("R10 B posted bit2", 32'(rsp_data[1][2]), 1);
    cmd(0, 8'h23, 16'h0, 0);
    check("R10 A incurred bit5", 32'(rsp_data[0][5]), 1);
    cmd(0, 8'h63, 16'h0, 0);
    check("R4 takeover by owner", 32'(rsp_cc[0]), 3);
    cmd(1, 8'h63, 16'h0, 0);
    check("R4 takeover cc", 32'(rsp_cc[1]), 7);
    check("R4 channel reset pulse", 32'(chan_rst), 1);
    check("R4 owner not yet moved", 32'(owner), 0);
    @(negedge clk);
    check("R4 owner moved", 32'(owner), 1);
    check("R4 reset pulse ended", 32'(chan_rst), 0);
    cmd(1, 8'h63, 16'h0, 0);
    check("R4 takeover when owning", 32'(rsp_cc[1]), 3);
  endtask

  task automatic t_dreset;
    cmd(1, 8'h6F, 16'h0, 1);
    check("R8 device reset cc", 32'(rsp_cc[1]), 7);
    check("R8 device reset clear irq", 32'(clr_irq), 32'b10);
    check("R8 device reset restarts owner timer", 32'(mon_restart), 1);
    cmd(0, 8'h23, 16'h0, 0);
    check("R8 reserve bit A cleared", 32'(rsp_data[0][3]), 0);
    cmd(0, 8'h6F, 16'h0, 0);
    check("R9 lamp cleared by device reset", 32'(ack), 0);
  endtask

  task automatic t_collide;
    @(negedge clk); load(0, 8'h50, 16'h0, 0); load(1, 8'h50, 16'h0, 0);
    @(negedge clk); cmd_valid = '0;
    check("R7 collision A", 32'(rsp_cc[0]), 7);
    check("R7 collision B busy", 32'(rsp_cc[1]), 1);
    check("R7 collision lamps", 32'(ack), 32'b01);
  endtask

  task automatic t_unknown;
    cmd(0, 8'h77, 16'h0, 0);
    check("R12 unknown code", 32'(rsp_cc[0]), 3);
    check("R12 unknown no data", 32'(rsp_data[0]), 0);
  endtask

  task automatic t_manual;
    @(negedge clk); manual = 1'b1; sel = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R11 manual owner A", 32'(owner), 0);
    check("R9 lamps cleared by operator", 32'(ack), 0);
    cmd(0, 8'h23, 16'h0, 0);
    check("R11 manual bit and mode alert", 32'({rsp_data[0][9], rsp_data[0][1]}), 32'b11);
    cmd(0, 8'h23, 16'h0, 0);
    check("R3 alert cleared by read", 32'(rsp_data[0][9]), 0);
    cmd(1, 8'h53, 16'h0, 0);
    check("R5 reserve in manual", 32'(rsp_cc[1]), 3);
    @(negedge clk); sel = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R11 manual owner B", 32'(owner), 1);
    cmd(1, 8'h23, 16'h0, 0);
    check("R11 select alert B", 32'({rsp_data[1][8], rsp_data[1][0]}), 32'b11);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset; t_read_id; t_status; t_ack; t_reserve; t_start; t_restart;
    t_takeover; t_dreset; t_collide; t_unknown; t_manual;
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule